// File: doc/BRIEF.md
# Pedestrian-Aware Traffic Signal Controller

This block sequences one red, one green and one amber lamp for a single approach. Time moves forward only in half-second steps, each marked by a one-cycle `tick_en` pulse from a divider outside the block. Left alone, the signal runs red, green, amber and back to red. Red has two parts: a wait part and a short green-soon part. A pedestrian request during the wait part jumps straight to green-soon, so green comes a fixed two seconds after the press.

A police pulse interrupts any normal phase and puts the signal into a paused mode in which only the amber lamp blinks. A second police pulse leaves that mode and restarts the cycle at the beginning of red with fresh timers. A quit pulse turns every lamp off for good. All request inputs are single-cycle pulses, already debounced and synchronous to `clk`.

Top module: `sig_lamp_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no further input, only the red lamp is lit.
- R2: With no requests, red lasts 16 ticks: 12 ticks of red-wait followed by 4 ticks of green-soon. Green comes on at the 16th tick.
- R3: A walk pulse in red-wait moves the controller to green-soon in the same cycle. Green then lights at the 4th tick after the press.
- R4: Green lasts 10 ticks and is followed by amber. Amber lasts 4 ticks and is followed by red-wait.
- R5: Walk pulses during green-soon, green or amber change nothing and are not stored. The next red still lasts the full 16 ticks.
- R6: A police pulse in any normal phase enters the paused mode with amber on and red and green off. Amber then toggles on every tick.
- R7: Walk pulses in the paused mode have no effect on the lamps or on the blink timing.
- R8: A police pulse in the paused mode returns the controller to red-wait with its timer cleared. The following red lasts 16 ticks.
- R9: A quit pulse in any state turns every lamp off, and no later input changes that.
- R10: When inputs coincide, quit wins over police. Police wins over walk and over timer expiry. Walk in red-wait wins over the expiry of the red-wait timer.
- R11: In every normal phase exactly one lamp is lit.
- R12: Without a tick or a request the state and the lamps hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released through a synchronizer. |
| tick_en | input | 1 | One-cycle pulse per half-second step |
| walk_req | input | 1 | Pedestrian crossing request pulse |
| police_req | input | 1 | Pause/resume toggle pulse |
| quit_req | input | 1 | Shutdown pulse |
| lamp_red | output | 1 | Red lamp on |
| lamp_green | output | 1 | Green lamp on |
| lamp_amber | output | 1 | Amber lamp on |

## Verification
The bench presses walk at every tick offset of red-wait, including the same cycle in which that timer expires. A design that restarted the wrong timer, or that let expiry win, would show green one or more ticks away from the fourth tick after the press. The bench also presses police at each of the 30 tick positions of a full cycle. A controller that kept a stale count, or that missed pre-emption in one phase, would resume with a red of the wrong length or keep a non-amber lamp lit. Walk pulses during the other phases, and during the blink mode, are followed by a full red. That red would be short if a request were latched. Coinciding quit, police and walk pulses expose a wrong priority order, and quit followed by long stretches of stimulus would reveal any way out of the dark state.

// File: rtl/sig_lamp_pkg.sv
package sig_lamp_pkg;

  typedef enum logic [2:0] {
    PH_RED_WAIT = 3'd0,
    PH_RED_SOON = 3'd1,
    PH_GREEN    = 3'd2,
    PH_AMBER    = 3'd3,
    PH_BLINK    = 3'd4,
    PH_DARK     = 3'd5
  } phase_e;

endpackage

// File: rtl/sig_rst_sync.sv
module sig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  // Assert at once, release after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/sig_phase_timer.sv
module sig_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_ce;

  assign expire = tick_en && (cnt_q == (limit - CNT_W'(1)));
  assign cnt_ce = clr || tick_en;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr)         cnt_nx = '0;
    else if (expire) cnt_nx = '0;
    else if (tick_en) cnt_nx = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_nx;
  end

  assign count = cnt_q;

  // R12: elapsed count never reaches the active phase length
  a_r12_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);

  // R12: without a tick or a clear the count holds
  a_r12_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/sig_phase_fsm.sv
module sig_phase_fsm
  import sig_lamp_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int WAIT_TICKS   = 12,
  parameter int SOON_TICKS   = 4,
  parameter int GREEN_TICKS  = 10,
  parameter int AMBER_TICKS  = 4,
  parameter int BLINK_TICKS  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             walk_req,
  input  logic             police_req,
  input  logic             quit_req,
  input  logic             expire,
  output phase_e           phase,
  output logic             blink_on,
  output logic [CNT_W-1:0] limit,
  output logic             timer_clr
);

  phase_e ph_q, ph_nx;
  logic   bl_q, bl_nx;
  logic   st_ce;

  // Phase length selected by the current phase.
  always_comb begin
    case (ph_q)
      PH_RED_WAIT: limit = CNT_W'(WAIT_TICKS);
      PH_RED_SOON: limit = CNT_W'(SOON_TICKS);
      PH_GREEN:    limit = CNT_W'(GREEN_TICKS);
      PH_AMBER:    limit = CNT_W'(AMBER_TICKS);
      PH_BLINK:    limit = CNT_W'(BLINK_TICKS);
      default:     limit = CNT_W'(1);
    endcase
  end

  // Next state: quit, then police, then walk, then timer expiry.
  always_comb begin
    ph_nx = ph_q;
    bl_nx = bl_q;
    if (ph_q != PH_DARK) begin
      if (quit_req) begin
        ph_nx = PH_DARK;
        bl_nx = 1'b0;
      end else if (police_req) begin
        if (ph_q == PH_BLINK) begin
          ph_nx = PH_RED_WAIT;
          bl_nx = 1'b0;
        end else begin
          ph_nx = PH_BLINK;
          bl_nx = 1'b1;
        end
      end else begin
        case (ph_q)
          PH_RED_WAIT: if (walk_req || expire) ph_nx = PH_RED_SOON;
          PH_RED_SOON: if (expire) ph_nx = PH_GREEN;
          PH_GREEN:    if (expire) ph_nx = PH_AMBER;
          PH_AMBER:    if (expire) ph_nx = PH_RED_WAIT;
          PH_BLINK:    if (expire) bl_nx = !bl_q;
          default:     ph_nx = ph_q;
        endcase
      end
    end
  end

  assign st_ce     = tick_en || walk_req || police_req || quit_req;
  assign timer_clr = (ph_nx != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_RED_WAIT;
      bl_q <= 1'b0;
    end else if (st_ce) begin
      ph_q <= ph_nx;
      bl_q <= bl_nx;
    end
  end

  assign phase    = ph_q;
  assign blink_on = bl_q;

  // R9: dark state is absorbing
  a_r9_dark_absorbing: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DARK) |=> (ph_q == PH_DARK));

  // R10: quit pre-empts everything else
  a_r10_quit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    quit_req |=> (ph_q == PH_DARK));

  // R6: police from a normal phase enters blink with amber on
  a_r6_police_enters_blink: assert property (@(posedge clk) disable iff (!rst_n)
    (police_req && !quit_req && ph_q != PH_BLINK && ph_q != PH_DARK)
      |=> (ph_q == PH_BLINK && bl_q));

  // R8: police in blink resumes at red-wait
  a_r8_police_resumes_red: assert property (@(posedge clk) disable iff (!rst_n)
    (police_req && !quit_req && ph_q == PH_BLINK) |=> (ph_q == PH_RED_WAIT));

  // R3: walk in red-wait jumps to green-soon
  a_r3_walk_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !police_req && !quit_req && ph_q == PH_RED_WAIT)
      |=> (ph_q == PH_RED_SOON));

  // R5: walk alone during green does nothing
  a_r5_walk_ignored_green: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !tick_en && !police_req && !quit_req && ph_q == PH_GREEN)
      |=> (ph_q == PH_GREEN));

endmodule

// File: rtl/sig_lamp_decode.sv
module sig_lamp_decode
  import sig_lamp_pkg::*;
(
  input  phase_e phase,
  input  logic   blink_on,
  output logic   lamp_red,
  output logic   lamp_green,
  output logic   lamp_amber
);

  always_comb begin
    lamp_red   = 1'b0;
    lamp_green = 1'b0;
    lamp_amber = 1'b0;
    case (phase)
      PH_RED_WAIT, PH_RED_SOON: lamp_red   = 1'b1;
      PH_GREEN:                 lamp_green = 1'b1;
      PH_AMBER:                 lamp_amber = 1'b1;
      PH_BLINK:                 lamp_amber = blink_on;
      default:                  lamp_amber = 1'b0;
    endcase
  end

endmodule

// File: rtl/sig_lamp_ctrl.sv
module sig_lamp_ctrl
  import sig_lamp_pkg::*;
#(
  parameter int WAIT_TICKS  = 12,
  parameter int SOON_TICKS  = 4,
  parameter int GREEN_TICKS = 10,
  parameter int AMBER_TICKS = 4,
  parameter int BLINK_TICKS = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic walk_req,
  input  logic police_req,
  input  logic quit_req,
  output logic lamp_red,
  output logic lamp_green,
  output logic lamp_amber
);

  localparam int MAX_A = (WAIT_TICKS > SOON_TICKS) ? WAIT_TICKS : SOON_TICKS;
  localparam int MAX_B = (GREEN_TICKS > AMBER_TICKS) ? GREEN_TICKS : AMBER_TICKS;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > BLINK_TICKS) ? MAX_C : BLINK_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             rst_core_n;
  logic             expire;
  logic             timer_clr;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;
  phase_e           phase;
  logic             blink_on;

  sig_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  sig_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (tick_en),
    .clr     (timer_clr),
    .limit   (limit),
    .expire  (expire),
    .count   (count)
  );

  sig_phase_fsm #(
    .CNT_W       (CNT_W),
    .WAIT_TICKS  (WAIT_TICKS),
    .SOON_TICKS  (SOON_TICKS),
    .GREEN_TICKS (GREEN_TICKS),
    .AMBER_TICKS (AMBER_TICKS),
    .BLINK_TICKS (BLINK_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick_en    (tick_en),
    .walk_req   (walk_req),
    .police_req (police_req),
    .quit_req   (quit_req),
    .expire     (expire),
    .phase      (phase),
    .blink_on   (blink_on),
    .limit      (limit),
    .timer_clr  (timer_clr)
  );

  sig_lamp_decode u_decode (
    .phase      (phase),
    .blink_on   (blink_on),
    .lamp_red   (lamp_red),
    .lamp_green (lamp_green),
    .lamp_amber (lamp_amber)
  );

  // R11: exactly one lamp in every normal phase
  a_r11_single_lamp: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase != PH_BLINK && phase != PH_DARK)
      |-> ($countones({lamp_red, lamp_green, lamp_amber}) == 1));

  // R9: dark state shows no lamp
  a_r9_dark_unlit: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase == PH_DARK) |-> !(lamp_red || lamp_green || lamp_amber));

  // R6: blink mode never lights red or green
  a_r6_blink_amber_only: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase == PH_BLINK) |-> !(lamp_red || lamp_green));

  // R12: the elapsed count stays within the phase length
  a_r12_count_in_range: assert property (@(posedge clk) disable iff (!rst_core_n)
    count < CNT_W'(MAX_T));

endmodule

// File: tb/sig_lamp_ctrl_test.sv
`timescale 1ns/1ps
module sig_lamp_ctrl_test;

  logic clk = 1'b0;
  logic rst_n, tick_en, walk_req, police_req, quit_req;
  logic lamp_red, lamp_green, lamp_amber;

  always #2.5 clk = ~clk;

  sig_lamp_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .walk_req   (walk_req),
    .police_req (police_req),
    .quit_req   (quit_req),
    .lamp_red   (lamp_red),
    .lamp_green (lamp_green),
    .lamp_amber (lamp_amber)
  );

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference model: 0 red-wait, 1 green-soon, 2 green, 3 amber, 4 blink, 5 dark
  int mph, mcnt;
  bit mbl;

  function automatic int dur(int p);
    case (p)
      0: return 12;
      1: return 4;
      2: return 10;
      3: return 4;
      4: return 1;
      default: return 1;
    endcase
  endfunction

  task automatic model_step(bit t, bit w, bit p, bit q);
    if (mph == 5) return;
    if (q) begin mph = 5; mcnt = 0; end
    else if (p) begin
      if (mph == 4) begin mph = 0; mbl = 0; end
      else begin mph = 4; mbl = 1; end
      mcnt = 0;
    end else if (mph == 0 && w) begin mph = 1; mcnt = 0; end
    else if (t) begin
      if (mcnt == dur(mph) - 1) begin
        mcnt = 0;
        case (mph)
          0: mph = 1;
          1: mph = 2;
          2: mph = 3;
          3: mph = 0;
          4: mbl = !mbl;
          default: ;
        endcase
      end else mcnt = mcnt + 1;
    end
  endtask

  task automatic check(string tag);
    logic [2:0] exp_l, got_l;
    case (mph)
      0, 1: exp_l = 3'b100;
      2:    exp_l = 3'b010;
      3:    exp_l = 3'b001;
      4:    exp_l = {2'b00, mbl};
      default: exp_l = 3'b000;
    endcase
    got_l = {lamp_red, lamp_green, lamp_amber};
    applied++;
    if (got_l !== exp_l) begin
      miscompares++;
      $display("FAIL %s: lamps rga=%b expected %b at %0t", tag, got_l, exp_l, $time);
    end
    if (mph < 4) begin
      applied++;
      if ($countones(got_l) != 1) begin
        miscompares++;
        $display("FAIL R11: lamps rga=%b expected exactly one lit", got_l);
      end
    end
  endtask

  task automatic step(bit t, bit w, bit p, bit q, string tag);
    @(negedge clk);
    tick_en = t; walk_req = w; police_req = p; quit_req = q;
    @(posedge clk);
    model_step(t, w, p, q);
    #1;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick_en = 0; walk_req = 0; police_req = 0; quit_req = 0;
    mph = 0; mcnt = 0; mbl = 0;
    @(posedge clk);
    #1;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, "R1");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick_en = 0; walk_req = 0; police_req = 0; quit_req = 0;
    mph = 0; mcnt = 0; mbl = 0;

    // R1, R2, R4, R12: undisturbed cycles with idle cycles between ticks
    do_reset();
    for (int i = 0; i < 45; i++) begin
      step(1, 0, 0, 0, (i < 16) ? "R2" : "R4");
      step(0, 0, 0, 0, "R12");
    end

    // R3: walk pressed at every red-wait offset
    for (int k = 0; k < 12; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) step(1, 0, 0, 0, "R3");
      step(0, 1, 0, 0, "R3");
      for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R3");
    end

    // R10: walk coinciding with red-wait expiry tick
    do_reset();
    for (int i = 0; i < 11; i++) step(1, 0, 0, 0, "R10");
    step(1, 1, 0, 0, "R10");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R10");

    // R5: walk during green-soon, green and amber is dropped
    do_reset();
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, "R5");
    for (int i = 0; i < 18; i++) begin
      step(0, 1, 0, 0, "R5");
      step(1, 1, 0, 0, "R5");
    end
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0, "R5");

    // R6, R7, R8: police at every tick position of one cycle
    for (int off = 0; off < 30; off++) begin
      do_reset();
      for (int i = 0; i < off; i++) step(1, 0, 0, 0, "R6");
      step(0, 0, 1, 0, "R6");
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, "R7");
      step(0, 1, 0, 0, "R7");
      step(1, 0, 1, 0, "R8");
      for (int i = 0; i < 18; i++) step(1, 0, 0, 0, "R8");
    end

    // R10: police beats walk and tick; quit beats police
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R10");
    step(1, 1, 1, 0, "R10");
    step(1, 0, 0, 0, "R10");
    step(1, 0, 1, 1, "R10");
    for (int i = 0; i < 20; i++) step(1, 1, 1, 0, "R9");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, "R9");

    // R9: quit from green and from blink
    do_reset();
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0, "R9");
    step(0, 0, 0, 1, "R9");
    for (int i = 0; i < 40; i++) step(1, i[0], i[1], 0, "R9");
    do_reset();
    step(0, 0, 1, 0, "R9");
    step(1, 0, 0, 1, "R9");
    for (int i = 0; i < 10; i++) step(1, 0, 1, 0, "R9");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule